// File: doc/BRIEF.md
# Masked Interrupt Vector Controller

This block collects a set of level-sensitive interrupt lines, gates them with a software-writable enable mask, and presents the result to a processor core. The core sees one interrupt request wire and an 8-bit vector bus. When exactly one enabled line is active, the vector names that line. When several enabled lines are active, the vector carries one shared "multiple pending" code, and software reads the masked status word to pick a source. The block does not rank sources by priority.

Software reaches the block through a single-beat register bus with a window of five 32-bit words. The words are the enable mask, the raw line levels, the masked levels, and two plain storage words reserved for non-maskable and debug status. Every request gets a registered response one clock later. The response flags accesses that fall outside the window or are not word-aligned.

Top module: `irq_vec_ctrl`

## Requirements
- R1: During and after reset, the mask, the storage words, the raw status, `irq_vec`, `irq_req`, `rsp_valid` and `rsp_err` are all zero.
- R2: The raw status word at byte offset 0x4 holds in bit i the level of `irq_lines[i]` sampled at the most recent clock edge. Bits 30 and 31 read as zero.
- R3: The mask word at offset 0x0 is a 32-bit read/write register. The masked status word at offset 0x8 reads as the raw status ANDed bitwise with the mask.
- R4: When exactly one masked bit i is set, `irq_vec` equals 0x31 + i and `irq_req` is high.
- R5: When two or more masked bits are set, `irq_vec` equals 0x30 and `irq_req` is high.
- R6: When no masked bit is set, `irq_vec` is 0 and `irq_req` is low.
- R7: `irq_vec` and `irq_req` reflect the line levels sampled at a clock edge, together with the mask as written at that same edge. A line change therefore appears one clock later, and a mask write appears on the edge that accepts it.
- R8: `bus_size` encodes 0 as byte, 1 as halfword and 2 as word. A request that is not word-sized reads as zero, has no write effect and does not raise `rsp_err`.
- R9: Writes to offsets 0x4 and 0x8 are discarded, and neither status word changes because of them.
- R10: An access at offset 0x14 or above, or with `bus_addr[1:0]` nonzero, reads as zero and has no write effect. Its response carries `rsp_err` high for one cycle.
- R11: The words at offsets 0xC and 0x10 are 32-bit read/write storage that affects nothing else.
- R12: Every request cycle is followed, in the next cycle, by exactly one cycle of `rsp_valid` with the read data in `bus_rdata`. Read data shows the register contents from before that request's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 30 | Level interrupt inputs, synchronous to clk |
| bus_req | input | 1 | Register access request, one beat |
| bus_we | input | 1 | Request is a write |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with rsp_valid |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Response flags an out-of-window or misaligned access |
| irq_vec | output | 8 | Vector to the core |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The encoder is driven with every single active line, every pair of active lines and the all-quiet pattern. These patterns separate the per-line vector offset, the shared multiple code and the idle state. A further sweep holds all lines high and walks a one-hot mask, which shows that gating happens before encoding and that a mask write takes effect on its own edge. The bus is exercised with sub-word sizes, read-only offsets, misaligned and out-of-window offsets, and storage words. Each case distinguishes an ignored access from one that silently changes a register, because the register is read back afterwards.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int unsigned WORD_BYTES   = 4;
   localparam int unsigned NUM_WORDS    = 5;
   localparam int unsigned WINDOW_BYTES = NUM_WORDS * WORD_BYTES;

   localparam int unsigned IDX_MASK = 0;
   localparam int unsigned IDX_RAW  = 1;
   localparam int unsigned IDX_GATE = 2;
   localparam int unsigned IDX_NMI  = 3;
   localparam int unsigned IDX_DBG  = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;
endpackage

// File: rtl/irqv_capture.sv
module irqv_capture #(
   parameter int unsigned NUM_LINES = 30
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   output logic [NUM_LINES-1:0] raw_o
);
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) raw_o[g] <= 1'b0;
         else        raw_o[g] <= lines_i[g];
      end
   end
endmodule

// File: rtl/irqv_encoder.sv
module irqv_encoder #(
   parameter int unsigned NUM_LINES = 30,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned VEC_BASE  = 8'h31,
   parameter int unsigned VEC_MULTI = 8'h30
) (
   input  logic [NUM_LINES-1:0] pend_i,
   output logic [VEC_W-1:0]     vec_o,
   output logic                 any_o
);
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   logic [IDX_W-1:0] low_idx;
   logic             multi;

   always_comb begin
      low_idx = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (pend_i[i]) low_idx = IDX_W'(i);
      end
   end

   if (NUM_LINES == 1) begin : g_single
      assign multi = 1'b0;
   end else begin : g_multi
      assign multi = |(pend_i & (pend_i - NUM_LINES'(1)));
   end

   assign any_o = |pend_i;

   always_comb begin
      if (!any_o)     vec_o = '0;
      else if (multi) vec_o = VEC_W'(VEC_MULTI);
      else            vec_o = VEC_W'(VEC_BASE) + VEC_W'(low_idx);
   end
endmodule

// File: rtl/irqv_regfile.sv
module irqv_regfile
   import irqv_pkg::*;
#(
   parameter int unsigned NUM_LINES = 30,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic                 we_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [1:0]           size_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic [NUM_LINES-1:0] raw_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic                 rsp_valid_o,
   output logic                 rsp_err_o,
   output logic [DATA_W-1:0]    mask_o,
   output logic [DATA_W-1:0]    mask_nxt_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [DATA_W-1:0] nmi_q, dbg_q, raw_ext, rd_val;
   logic [IDX_W-1:0]  idx;
   logic              aligned, in_win, bad, full_word, hit;

   assign raw_ext   = DATA_W'(raw_i);
   assign idx       = addr_i[ADDR_W-1:2];
   assign aligned   = (addr_i[1:0] == 2'b00);
   assign in_win    = (32'(addr_i) < WINDOW_BYTES);
   assign bad       = !(aligned && in_win);
   assign full_word = (acc_size_e'(size_i) == SZ_WORD);
   assign hit       = req_i && !bad && full_word;

   always_comb begin
      mask_nxt_o = mask_o;
      if (hit && we_i && (32'(idx) == IDX_MASK)) mask_nxt_o = wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o <= '0;
         nmi_q  <= '0;
         dbg_q  <= '0;
      end else begin
         mask_o <= mask_nxt_o;
         if (hit && we_i && (32'(idx) == IDX_NMI)) nmi_q <= wdata_i;
         if (hit && we_i && (32'(idx) == IDX_DBG)) dbg_q <= wdata_i;
      end
   end

   always_comb begin
      rd_val = '0;
      if (hit) begin
         case (32'(idx))
            IDX_MASK: rd_val = mask_o;
            IDX_RAW:  rd_val = raw_ext;
            IDX_GATE: rd_val = raw_ext & mask_o;
            IDX_NMI:  rd_val = nmi_q;
            IDX_DBG:  rd_val = dbg_q;
            default:  rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o     <= '0;
         rsp_valid_o <= 1'b0;
         rsp_err_o   <= 1'b0;
      end else begin
         rdata_o     <= rd_val;
         rsp_valid_o <= req_i;
         rsp_err_o   <= req_i && bad;
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int unsigned NUM_LINES = 30,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned VEC_BASE  = 8'h31,
   parameter int unsigned VEC_MULTI = 8'h30
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 bus_req,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [VEC_W-1:0]     irq_vec,
   output logic                 irq_req
);
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("irq_vec_ctrl: NUM_LINES must be 1..DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("irq_vec_ctrl: ADDR_W too small for the register window");
   end
   if (VEC_BASE + NUM_LINES - 1 >= (1 << VEC_W) || VEC_MULTI >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_vec_ctrl: vector codes do not fit VEC_W");
   end

   logic [NUM_LINES-1:0] raw_q;
   logic [DATA_W-1:0]    mask_q, mask_nxt;
   logic [VEC_W-1:0]     vec_d;
   logic                 any_d;

   irqv_capture #(.NUM_LINES(NUM_LINES)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .lines_i(irq_lines),
      .raw_o  (raw_q)
   );

   irqv_regfile #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (bus_req),
      .we_i       (bus_we),
      .addr_i     (bus_addr),
      .size_i     (bus_size),
      .wdata_i    (bus_wdata),
      .raw_i      (raw_q),
      .rdata_o    (bus_rdata),
      .rsp_valid_o(rsp_valid),
      .rsp_err_o  (rsp_err),
      .mask_o     (mask_q),
      .mask_nxt_o (mask_nxt)
   );

   irqv_encoder #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                  .VEC_MULTI(VEC_MULTI)) u_enc (
      .pend_i(irq_lines & mask_nxt[NUM_LINES-1:0]),
      .vec_o (vec_d),
      .any_o (any_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_vec <= '0;
         irq_req <= 1'b0;
      end else begin
         irq_vec <= vec_d;
         irq_req <= any_d;
      end
   end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
   parameter int unsigned NUM_LINES = 30,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned VEC_BASE  = 8'h31,
   parameter int unsigned VEC_MULTI = 8'h30
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic                 bus_req,
   input logic                 bus_we,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 rsp_valid,
   input logic                 rsp_err,
   input logic [VEC_W-1:0]     irq_vec,
   input logic                 irq_req,
   input logic [NUM_LINES-1:0] raw_q,
   input logic [DATA_W-1:0]    mask_q
);
   logic [NUM_LINES-1:0] gated;
   logic                 bad_acc;
   assign gated   = raw_q & mask_q[NUM_LINES-1:0];
   assign bad_acc = (bus_addr[1:0] != 2'b00) || (32'(bus_addr) >= 32'd20);

   AST_RAW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> raw_q == $past(irq_lines)); // R2
   AST_ONE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(gated) == 1) |-> (irq_req && irq_vec >= VEC_W'(VEC_BASE))); // R4
   AST_MULTI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(gated) > 1) |-> (irq_req && irq_vec == VEC_W'(VEC_MULTI))); // R5
   AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (gated == '0) |-> (!irq_req && irq_vec == '0)); // R6
   AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bus_req && bus_we && bad_acc)) |-> mask_q == $past(mask_q)); // R10
   AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid); // R10
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> rsp_valid == $past(bus_req)); // R12
endmodule

bind irq_vec_ctrl irqv_chk #(
   .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_MULTI(VEC_MULTI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_req(bus_req),
   .bus_we(bus_we), .bus_addr(bus_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
   .irq_vec(irq_vec), .irq_req(irq_req), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_lines = '0;
   logic          bus_req = 1'b0, bus_we = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [1:0]    bus_size = 2'd2;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          rsp_valid, rsp_err, irq_req;
   logic [7:0]    irq_vec;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vec_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .irq_vec(irq_vec), .irq_req(irq_req)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_vec(input logic [NL-1:0] m);
      int cnt = 0;
      int low = -1;
      for (int i = 0; i < NL; i++) begin
         if (m[i]) begin
            cnt++;
            if (low < 0) low = i;
         end
      end
      if (cnt == 0) return 8'h00;
      if (cnt > 1)  return 8'h30;
      return 8'(8'h31 + low);
   endfunction

   task automatic access(input bit we, input logic [4:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output logic err);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
      check(rsp_valid === 1'b1, "R12 rsp_valid", 32'(rsp_valid), 32'd1);
      rd = bus_rdata;
      err = rsp_err;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      logic [31:0] rd;
      logic err;
      access(1'b1, a, 2'd2, d, rd, err);
   endtask

   task automatic rd_word(input logic [4:0] a, output logic [31:0] d);
      logic err;
      access(1'b0, a, 2'd2, '0, d, err);
   endtask

   task automatic apply_lines(input logic [NL-1:0] v);
      @(negedge clk);
      irq_lines = v;
      @(negedge clk);
   endtask

   task automatic check_vec(input logic [NL-1:0] gated, input string tag);
      logic [7:0] e;
      e = ref_vec(gated);
      check(irq_vec === e, tag, 32'(irq_vec), 32'(e));
      check(irq_req === (gated != '0), tag, 32'(irq_req), 32'(gated != '0));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic        err;
      logic [NL-1:0] all1;
      all1 = '1;

      // R1: reset state, with lines active during reset
      irq_lines = all1;
      repeat (3) @(negedge clk);
      check(irq_vec === 8'h00 && irq_req === 1'b0, "R1 outputs in reset", 32'(irq_vec), 32'd0);
      check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R1 rsp in reset", 32'({rsp_valid, rsp_err}), 32'd0);
      irq_lines = '0;
      rst_n = 1'b1;
      @(negedge clk);
      rd_word(5'h00, d); check(d === 32'd0, "R1 mask after reset", d, 32'd0);
      rd_word(5'h0C, d); check(d === 32'd0, "R1 nmi word after reset", d, 32'd0);
      rd_word(5'h10, d); check(d === 32'd0, "R1 debug word after reset", d, 32'd0);
      check_vec('0, "R6 idle after reset");

      // R3: mask read/write
      wr(5'h00, 32'hFFFF_FFFF);
      rd_word(5'h00, d); check(d === 32'hFFFF_FFFF, "R3 mask readback", d, 32'hFFFF_FFFF);

      // R4/R2/R3: walk a single line
      for (int i = 0; i < NL; i++) begin
         apply_lines(NL'(1) << i);
         check_vec(NL'(1) << i, "R4 single line vector");
         rd_word(5'h04, d); check(d === (32'd1 << i), "R2 raw status single", d, 32'd1 << i);
      end

      // R5: every pair
      for (int i = 0; i < NL; i++) begin
         for (int j = i + 1; j < NL; j++) begin
            apply_lines((NL'(1) << i) | (NL'(1) << j));
            check_vec((NL'(1) << i) | (NL'(1) << j), "R5 pair vector");
         end
      end
      apply_lines(all1);
      check_vec(all1, "R5 all lines");
      rd_word(5'h04, d); check(d === 32'h3FFF_FFFF, "R2 raw upper bits zero", d, 32'h3FFF_FFFF);
      apply_lines('0);
      check_vec('0, "R6 no line");

      // R7: line change latency
      @(negedge clk);
      irq_lines = NL'(1) << 5;
      @(posedge clk); #1;
      @(negedge clk);
      check(irq_vec === 8'h36, "R7 line change after one edge", 32'(irq_vec), 32'h36);
      @(negedge clk);
      irq_lines = '0;
      #1;
      check(irq_vec === 8'h36, "R7 no change before edge", 32'(irq_vec), 32'h36);
      @(negedge clk);
      check(irq_vec === 8'h00, "R7 cleared after edge", 32'(irq_vec), 32'h00);

      // R3/R4/R7: all lines high, walk one-hot mask
      apply_lines(all1);
      for (int i = 0; i < NL; i++) begin
         wr(5'h00, 32'd1 << i);
         check_vec(NL'(1) << i, "R7 mask write same edge");
         rd_word(5'h08, d); check(d === (32'd1 << i), "R3 masked status", d, 32'd1 << i);
      end
      wr(5'h00, 32'hC000_0000);
      check_vec('0, "R6 mask only above lines");
      rd_word(5'h08, d); check(d === 32'd0, "R3 masked status empty", d, 32'd0);

      // R9: read-only status words
      apply_lines(NL'(32'h0000_0F0F));
      wr(5'h00, 32'h0000_00FF);
      wr(5'h04, 32'hFFFF_FFFF);
      rd_word(5'h04, d); check(d === 32'h0000_0F0F, "R9 raw write discarded", d, 32'h0000_0F0F);
      wr(5'h08, 32'hFFFF_FFFF);
      rd_word(5'h08, d); check(d === 32'h0000_000F, "R9 masked write discarded", d, 32'h0000_000F);
      check_vec(NL'(32'h0F), "R9 vector unchanged");

      // R8: sub-word accesses
      access(1'b1, 5'h00, 2'd0, 32'hFFFF_FFFF, d, err);
      check(err === 1'b0, "R8 byte write no error", 32'(err), 32'd0);
      access(1'b1, 5'h00, 2'd1, 32'hFFFF_FFFF, d, err);
      rd_word(5'h00, d); check(d === 32'h0000_00FF, "R8 subword write ignored", d, 32'h0000_00FF);
      access(1'b0, 5'h00, 2'd0, '0, d, err);
      check(d === 32'd0 && err === 1'b0, "R8 byte read zero", d, 32'd0);
      access(1'b0, 5'h04, 2'd1, '0, d, err);
      check(d === 32'd0 && err === 1'b0, "R8 half read zero", d, 32'd0);

      // R11: storage words
      wr(5'h0C, 32'hA5A5_1234);
      wr(5'h10, 32'h5A5A_8765);
      rd_word(5'h0C, d); check(d === 32'hA5A5_1234, "R11 nmi word", d, 32'hA5A5_1234);
      rd_word(5'h10, d); check(d === 32'h5A5A_8765, "R11 debug word", d, 32'h5A5A_8765);
      rd_word(5'h00, d); check(d === 32'h0000_00FF, "R11 mask untouched", d, 32'h0000_00FF);

      // R10: out of window and misaligned
      for (int a = 20; a < 32; a += 4) begin
         access(1'b0, 5'(a), 2'd2, '0, d, err);
         check(d === 32'd0 && err === 1'b1, "R10 out of window read", {d[30:0], err}, 32'd1);
      end
      access(1'b1, 5'h02, 2'd2, 32'hFFFF_FFFF, d, err);
      check(err === 1'b1, "R10 misaligned write err", 32'(err), 32'd1);
      access(1'b0, 5'h01, 2'd2, '0, d, err);
      check(d === 32'd0 && err === 1'b1, "R10 misaligned read", d, 32'd0);
      access(1'b1, 5'h14, 2'd2, 32'hFFFF_FFFF, d, err);
      rd_word(5'h00, d); check(d === 32'h0000_00FF, "R10 mask unchanged", d, 32'h0000_00FF);
      @(negedge clk);
      check(rsp_err === 1'b0 && rsp_valid === 1'b0, "R10 err one cycle", 32'({rsp_valid, rsp_err}), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule